// File: doc/BRIEF.md
# Nonlinear-Filtered LFSR Keystream Generator

This block is a 48-bit stream cipher engine for a low-frequency transponder link. A start strobe captures a 48-bit key, a 32-bit serial number and a 32-bit initial vector. The engine then runs 32 keyed initialisation steps. During these steps every new register bit mixes the nonlinear filter output with one IV bit and one key bit. After initialisation the register runs as a plain linear feedback shift register. Each keystream bit is the output of a two-level, table-driven filter over 20 of the state bits. The register bits themselves never appear at the output.

Three request types are accepted once the engine is idle:
- A single-bit request returns one keystream bit.
- A byte request XORs up to eight keystream bits into a data byte, starting at the MSB.
- An authenticate request draws four keystream bytes, complements them and compares the result with a supplied 32-bit value.

The caller supplies key, serial and IV already in cipher bit order.

Top module: `lfsr_keystream_gen`

## Requirements
- R1: A start strobe loads the state with key[15:0] in bits 47..32 and serial in bits 31..0. From the next cycle `busy` is high for exactly 32 cycles.
- R2: Initialisation step i (i = 0..31) shifts the state right by one. The new bit 47 is filter(state) XOR iv[i] XOR key[i+16]. Key and IV are captured at the start strobe, so later changes on the pins have no effect.
- R3: Every keystream step shifts right by one. The new bit 47 is the XOR of state bits 0, 2, 3, 6, 7, 8, 16, 22, 23, 26, 30, 41, 42, 43, 46 and 47.
- R4: Each keystream bit is filter(state), taken before the shift. The filter forms a 5-bit index from five 4-input lookups. Each lookup takes its first listed bit as the LSB, and the lookups fill the index LSB first:
  - table 0x2C79 on bits {1,2,4,5};
  - table 0x6671 on bits {7,11,13,14};
  - table 0x6671 on bits {16,20,22,25};
  - table 0x6671 on bits {27,28,30,32};
  - table 0x2C79 on bits {33,42,43,45}.
  The index then selects one bit of 0x7907287B.
- R5: A bit request accepted in idle gives `ks_vld` high for one cycle on the following cycle, with `ks_bit` holding the keystream bit.
- R6: A byte request with `byte_len` = 0 uses 8 bits. The first keystream bit goes to bit 7. `data_out` = `data_in` XOR the keystream byte. `done` pulses n+1 cycles after the request cycle, where n is the number of bits.
- R7: A byte request with `byte_len` = n (1..7) XORs keystream into bits 7 down to 8-n only. The lower bits pass through unchanged.
- R8: An authenticate request draws 32 keystream bits, and `auth_val[31:24]` is compared against the first byte. `match` is set only if all 32 bits of `auth_val` equal the complemented keystream. `match` and `done` update 33 cycles after the request cycle, and `match` holds until the next update or start.
- R9: While `busy` is high (initialisation, byte or authenticate operation), all requests are ignored. No `ks_vld` is produced and the state does not advance for them.
- R10: Reset clears the state, `busy`, `ks_vld`, `ks_bit`, `done`, `match` and `data_out`.
- R11: A start strobe aborts any operation in progress without a `done` pulse and reloads the state as in R1.
- R12: Simultaneous requests in idle are served in the order authenticate, then byte, then bit. Only one is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load key, serial and IV and begin initialisation |
| key | input | 48 | Cipher key in cipher bit order |
| serial | input | 32 | Serial number in cipher bit order |
| iv | input | 32 | Initial vector in cipher bit order |
| bit_req | input | 1 | Request one keystream bit |
| byte_req | input | 1 | Request an XOR of keystream into `data_in` |
| auth_req | input | 1 | Request an authenticator check of `auth_val` |
| byte_len | input | 3 | Bits for a byte request, 0 meaning 8 |
| data_in | input | 8 | Byte to be XORed with keystream |
| auth_val | input | 32 | Authenticator to compare, first byte in bits 31..24 |
| busy | output | 1 | Initialisation or multi-step operation running |
| ks_bit | output | 1 | Keystream bit from the last bit request |
| ks_vld | output | 1 | One-cycle strobe for `ks_bit` |
| data_out | output | 8 | Result of the last byte request |
| done | output | 1 | One-cycle strobe ending a byte or authenticate request |
| match | output | 1 | Result of the last authenticate request |

## Verification
A wrong bit anywhere in the 48-bit state, or a wrong tap or table constant, gives a wrong keystream bit within a few requests. It shows first at `ks_bit` or `data_out`, and it keeps spreading, because the filter reads bits spread over the whole register. A fault in the init mixing or in the captured key and IV corrupts every bit after the first `busy` fall.

A wrong step counter shows in two ways: a `busy` or `done` pulse at the wrong cycle, or a keystream that is shifted against a model advanced by the same requests. The authenticate path is checked with an exact value and with a one-bit-flipped value, so a partial compare would be caught.

// File: rtl/lfsr_keystream_gen.sv
module lfsr_keystream_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] key,
  input  logic [31:0] serial,
  input  logic [31:0] iv,
  input  logic        bit_req,
  input  logic        byte_req,
  input  logic        auth_req,
  input  logic [2:0]  byte_len,
  input  logic [7:0]  data_in,
  input  logic [31:0] auth_val,
  output logic        busy,
  output logic        ks_bit,
  output logic        ks_vld,
  output logic [7:0]  data_out,
  output logic        done,
  output logic        match
);
  localparam logic [15:0] LUT_A    = 16'h2C79;
  localparam logic [15:0] LUT_B    = 16'h6671;
  localparam logic [31:0] LUT_C    = 32'h7907287B;
  localparam logic [47:0] TAP_MASK = 48'hCE00_44C1_01CD;
  localparam int          STEPS    = 32;
  localparam logic [4:0]  LAST     = 5'(STEPS - 1);

  typedef enum logic [1:0] {IDLE, INIT, XBYTE, AUTH} mode_t;

  mode_t       mode;
  logic [47:0] st;
  logic [31:0] kreg, ireg, aval, acc;
  logic [4:0]  cnt;
  logic [3:0]  nlen;
  logic [7:0]  dreg;

  function automatic logic filt(input logic [47:0] s);
    logic [4:0] ix;
    ix[0] = LUT_A[{s[5],  s[4],  s[2],  s[1]}];
    ix[1] = LUT_B[{s[14], s[13], s[11], s[7]}];
    ix[2] = LUT_B[{s[25], s[22], s[20], s[16]}];
    ix[3] = LUT_B[{s[32], s[30], s[28], s[27]}];
    ix[4] = LUT_A[{s[45], s[43], s[42], s[33]}];
    return LUT_C[ix];
  endfunction

  logic        ks_now;
  logic [47:0] st_run, st_init;
  logic [7:0]  dnext;
  logic [31:0] anext;

  assign ks_now  = filt(st);
  assign st_run  = {^(st & TAP_MASK), st[47:1]};
  assign st_init = {ks_now ^ ireg[cnt] ^ kreg[cnt], st[47:1]};
  assign dnext   = dreg ^ ({7'd0, ks_now} << (3'd7 - cnt[2:0]));
  assign anext   = {acc[30:0], ks_now};
  assign busy    = (mode != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= IDLE; st <= '0; kreg <= '0; ireg <= '0; aval <= '0; acc <= '0;
      cnt <= '0; nlen <= '0; dreg <= '0; data_out <= '0;
      ks_bit <= 1'b0; ks_vld <= 1'b0; done <= 1'b0; match <= 1'b0;
    end else begin
      ks_vld <= 1'b0;
      done   <= 1'b0;
      if (start) begin
        st    <= {key[15:0], serial};
        kreg  <= key[47:16];
        ireg  <= iv;
        cnt   <= '0;
        mode  <= INIT;
        match <= 1'b0;
      end else begin
        case (mode)
          INIT: begin
            st  <= st_init;
            cnt <= cnt + 5'd1;
            if (cnt == LAST) mode <= IDLE;
          end
          XBYTE: begin
            st   <= st_run;
            dreg <= dnext;
            cnt  <= cnt + 5'd1;
            if (cnt[3:0] == nlen - 4'd1) begin
              data_out <= dnext;
              done     <= 1'b1;
              mode     <= IDLE;
            end
          end
          AUTH: begin
            st  <= st_run;
            acc <= anext;
            cnt <= cnt + 5'd1;
            if (cnt == LAST) begin
              match <= (aval == ~anext);
              done  <= 1'b1;
              mode  <= IDLE;
            end
          end
          default: begin
            if (auth_req) begin
              mode <= AUTH; aval <= auth_val; cnt <= '0;
            end else if (byte_req) begin
              mode <= XBYTE; dreg <= data_in; cnt <= '0;
              nlen <= (byte_len == 3'd0) ? 4'd8 : {1'b0, byte_len};
            end else if (bit_req) begin
              ks_bit <= ks_now;
              ks_vld <= 1'b1;
              st     <= st_run;
            end
          end
        endcase
      end
    end
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done));

  // R5
  ks_vld_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ks_vld |-> $past(bit_req && !byte_req && !auth_req && !busy && !start));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> !ks_vld);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !bit_req && !byte_req && !auth_req) |=> $stable(st));

  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> $stable(match));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_lfsr_keystream_gen.sv
module tb_lfsr_keystream_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [111:0] VEC [0:3] = '{
    {48'h524B494D4E4F, 32'h02204E02, 32'h00000000},
    {48'hFFFFFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {48'h0123456789AB, 32'hDEADBEEF, 32'h13579BDF},
    {48'h000000000000, 32'h00000000, 32'h00000000}
  };
  localparam int TAPS [0:15] = '{0,2,3,6,7,8,16,22,23,26,30,41,42,43,46,47};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:0] key_i = '0;
  logic [31:0] ser_i = '0, iv_i = '0, aval_i = '0;
  logic bit_req = 1'b0, byte_req = 1'b0, auth_req = 1'b0;
  logic [2:0] len_i = '0;
  logic [7:0] din = '0;
  logic busy, ks_bit, ks_vld, done, match;
  logic [7:0] data_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [47:0] ms;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_keystream_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key_i), .serial(ser_i), .iv(iv_i),
    .bit_req(bit_req), .byte_req(byte_req), .auth_req(auth_req), .byte_len(len_i),
    .data_in(din), .auth_val(aval_i), .busy(busy), .ks_bit(ks_bit), .ks_vld(ks_vld),
    .data_out(data_out), .done(done), .match(match));

  function automatic logic lk(input logic [15:0] t, input int b0, input int b1,
                              input int b2, input int b3, input logic [47:0] s);
    return t[{s[b3], s[b2], s[b1], s[b0]}];
  endfunction

  function automatic logic m_filt(input logic [47:0] s);
    logic [4:0] ix;
    ix = {lk(16'h2C79, 33, 42, 43, 45, s), lk(16'h6671, 27, 28, 30, 32, s),
          lk(16'h6671, 16, 20, 22, 25, s), lk(16'h6671, 7, 11, 13, 14, s),
          lk(16'h2C79, 1, 2, 4, 5, s)};
    return logic'(32'h7907287B >> ix);
  endfunction

  function automatic logic [47:0] m_step(input logic [47:0] s);
    logic fb = 1'b0;
    for (int i = 0; i < 16; i++) fb ^= s[TAPS[i]];
    return {fb, s[47:1]};
  endfunction

  function automatic logic [47:0] m_init(input logic [47:0] k, input logic [31:0] sr,
                                         input logic [31:0] v);
    logic [47:0] s = {k[15:0], sr};
    for (int i = 0; i < 32; i++) s = {m_filt(s) ^ v[i] ^ k[i+16], s[47:1]};
    return s;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_start(input logic [47:0] k, input logic [31:0] s,
                          input logic [31:0] v, input bit chk_len);
    int n = 0;
    @(negedge clk); key_i = k; ser_i = s; iv_i = v; start = 1'b1;
    @(negedge clk); start = 1'b0; key_i = ~k; iv_i = ~v; ser_i = ~s;
    while (busy && n < 100) begin n++; @(negedge clk); end
    ms = m_init(k, s, v);
    if (chk_len) check("R1", "busy cycles", 64'(n), 64'd32);
  endtask

  task automatic get_bit();
    @(negedge clk); bit_req = 1'b1;
    @(negedge clk); bit_req = 1'b0;
    check("R5", "ks_vld", 64'(ks_vld), 64'd1);
    check("R2 R3 R4 R5", "ks_bit", 64'(ks_bit), 64'(m_filt(ms)));
    ms = m_step(ms);
  endtask

  task automatic do_byte(input logic [7:0] d, input logic [2:0] len, input string req);
    int n, cyc;
    logic [7:0] e = d;
    n = (len == 3'd0) ? 8 : int'(len);
    for (int k = 0; k < n; k++) begin e[7-k] ^= m_filt(ms); ms = m_step(ms); end
    @(negedge clk); byte_req = 1'b1; din = d; len_i = len;
    @(negedge clk); byte_req = 1'b0; cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check(req, "data_out", 64'(data_out), 64'(e));
    check("R6", "byte latency", 64'(cyc), 64'(n + 1));
  endtask

  task automatic do_auth(input logic [31:0] flip);
    int cyc;
    logic [31:0] ks = '0;
    for (int k = 0; k < 32; k++) begin ks = {ks[30:0], m_filt(ms)}; ms = m_step(ms); end
    @(negedge clk); auth_req = 1'b1; aval_i = ~ks ^ flip;
    @(negedge clk); auth_req = 1'b0; cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check("R8", "match", 64'(match), 64'(flip == 32'd0));
    check("R8", "auth latency", 64'(cyc), 64'd33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "busy", 64'(busy), 64'd0);
    check("R10", "outs", 64'({ks_vld, ks_bit, done, match, data_out}), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      do_start(VEC[v][111:64], VEC[v][63:32], VEC[v][31:0], 1'b1);
      for (int b = 0; b < 8; b++) get_bit();
      do_byte(8'hA5 ^ 8'(v), 3'd0, "R6");
      do_auth(32'd0);
      do_auth(v[0] ? 32'h8000_0000 : 32'h0000_0001);
    end

    // R7 partial bytes
    do_start(48'h13579BDF2468, 32'h0BADF00D, 32'hCAFEBABE, 1'b0);
    do_byte(8'h3C, 3'd3, "R7");
    do_byte(8'hFF, 3'd1, "R7");
    do_byte(8'h00, 3'd7, "R7");

    // R9 requests during init are ignored
    @(negedge clk); key_i = 48'hA1B2C3D4E5F6; ser_i = 32'h11223344; iv_i = 32'h55667788; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    bit_req = 1'b1;
    @(negedge clk); bit_req = 1'b0;
    check("R9", "ks_vld in init", 64'(ks_vld), 64'd0);
    while (busy) @(negedge clk);
    ms = m_init(48'hA1B2C3D4E5F6, 32'h11223344, 32'h55667788);
    get_bit();

    // R9 bit request during byte operation ignored
    begin
      logic [7:0] e = 8'h5A;
      for (int k = 0; k < 8; k++) begin e[7-k] ^= m_filt(ms); ms = m_step(ms); end
      @(negedge clk); byte_req = 1'b1; din = 8'h5A; len_i = 3'd0;
      @(negedge clk); byte_req = 1'b0; bit_req = 1'b1;
      @(negedge clk); bit_req = 1'b0;
      check("R9", "ks_vld in byte op", 64'(ks_vld), 64'd0);
      while (!done) @(negedge clk);
      check("R9", "data_out after ignored req", 64'(data_out), 64'(e));
      get_bit();
    end

    // R12 byte wins over bit
    begin
      logic [7:0] e = 8'h81;
      for (int k = 0; k < 2; k++) begin e[7-k] ^= m_filt(ms); ms = m_step(ms); end
      @(negedge clk); byte_req = 1'b1; bit_req = 1'b1; din = 8'h81; len_i = 3'd2;
      @(negedge clk); byte_req = 1'b0; bit_req = 1'b0;
      check("R12", "ks_vld with byte", 64'(ks_vld), 64'd0);
      while (!done) @(negedge clk);
      check("R12", "data_out", 64'(data_out), 64'(e));
      get_bit();
    end

    // R11 abort of authenticate by start
    @(negedge clk); auth_req = 1'b1; aval_i = 32'h0;
    @(negedge clk); auth_req = 1'b0;
    repeat (4) @(negedge clk);
    do_start(48'h0F1E2D3C4B5A, 32'h99887766, 32'h10203040, 1'b1);
    check("R11", "done after abort", 64'(done), 64'd0);
    get_bit();
    do_byte(8'h77, 3'd0, "R11");

    // R10 reset mid-operation after a match
    do_auth(32'd0);
    @(negedge clk); byte_req = 1'b1; din = 8'hF0; len_i = 3'd0;
    @(negedge clk); byte_req = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10", "busy after reset", 64'(busy), 64'd0);
    check("R10", "outs after reset", 64'({ks_vld, ks_bit, done, match, data_out}), 64'd0);
    rst_n = 1'b1;
    ms = '0;
    get_bit();

    finish_run();
  end
endmodule